// File: doc/BRIEF.md
# Dual-Domain Tick Down-Counter

This block is a slow-clock down-counter meant to drive an operating-system tick. Software reaches it through a small register port clocked by a fast bus clock. The counter itself runs on a separate 32768 Hz clock and moves down by one on each slow edge. When the count reaches zero, the counter reloads from the reload value and raises an expiry event. The event is kept in a sticky status bit and can drive a level interrupt.

Every control action crosses between the two clocks. A rising start bit, a falling start bit and a reload-value write each reach the slow domain as a single event through a toggle handshake. Load acknowledgements, expiries and count updates come back the same way. Because of this crossing, the count register reads zero for a short window after start, until the slow domain has loaded the counter. The start bit reads as set during that window. A read-only "counting" flag tells software when the load is done.

Register map (2-bit address, 32-bit data):
- Address 0: reload value, bits 27:0, read/write.
- Address 1: control. Bit 0 is enable, bit 1 is interrupt enable, bit 2 is halt-on-debug, bit 3 is start.
- Address 2: count, read-only.
- Address 3: status. Bit 0 is expired (write 1 to clear). Bit 1 is counting (read-only).

Top module: `lft_tick_timer`

## Requirements
- R1: While started, enabled and not halted, the count drops by exactly one per slow-clock cycle.
- R2: Count and reload value are 28 bits wide. Bits 31:28 of address 0 and of address 2 always read as zero, so writing 0xFFFFFFFF to address 0 reads back 0x0FFFFFFF.
- R3: The count is loaded from the reload value only when control bit 3 goes from 0 to 1. Writes to address 2 have no effect.
- R4: After the count reaches zero it reloads from the latest reload value, giving a period of reload+1 slow cycles. A reload-value write while running does not change the current count.
- R5: Between a start write and the slow-domain load, address 2 reads zero while control bit 3 reads as one.
- R6: Status bit 1 reads one once the started counter is loaded. It reads zero while start is clear.
- R7: Each expiry sets status bit 0, which stays set until software writes 1 to it. That write is ignored while control bit 3 is set.
- R8: irq_out is high one bus cycle after status bit 0 and control bit 1 are both high. It stays low while control bit 1 is clear.
- R9: With control bit 0 clear, a started counter holds its value.
- R10: When control bit 2 is set and dbg_halt is high, the count freezes. dbg_halt has no effect while control bit 2 is clear.
- R11: After reset, all four addresses read zero and irq_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast register-port clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| slow_clk | input | 1 | 32768 Hz counting clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| reg_wr | input | 1 | Write strobe, one bus cycle per write |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| dbg_halt | input | 1 | External debug-halt request, asynchronous |
| irq_out | output | 1 | Level interrupt, bus domain |

## Verification
The bound checker watches the slow-domain rules on every cycle: a one-step decrement, a reload from the shadowed reload value, holding while inactive, and loading on a synchronized start. In the bus domain it checks that a pending start reads zero, that status stays sticky while started, that the interrupt is gated, and that the upper count bits are zero. Some behaviour depends on how long the crossings take, so only the bench scenarios can show it. This includes the reload period seen through the register port, the length of the zero-read window after start, and a reload-value change that takes effect only at the next reload. It also includes the debug-halt and enable freezes as software observes them.

// File: rtl/lft_pkg.sv
package lft_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 2;
    localparam int CNT_W_DEF  = 28;
    localparam int SYNC_DEF   = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_RELOAD = 2'd0,
        ADR_CTRL   = 2'd1,
        ADR_COUNT  = 2'd2,
        ADR_STATUS = 2'd3
    } lft_addr_e;

    // packed MSB first: start is bit 3, enable is bit 0
    typedef struct packed {
        logic start;
        logic halt_en;
        logic irq_en;
        logic enable;
    } lft_ctrl_t;

    localparam int CTRL_W = $bits(lft_ctrl_t);

    typedef struct packed {
        logic counting;
        logic expired;
    } lft_status_t;

    localparam int STAT_W = $bits(lft_status_t);

    function automatic logic [DATA_W-1:0] lft_zext(input logic [DATA_W-1:0] v, input int width);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < width) m[i] = v[i];
        end
        return m;
    endfunction
endpackage

// File: rtl/lft_sync.sv
module lft_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lft_pulse_xing.sv
module lft_pulse_xing #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic dst_pulse
);
    logic tgl_q;
    logic tgl_s;
    logic tgl_d;

    always_ff @(posedge src_clk) begin
        if (src_rst)        tgl_q <= 1'b0;
        else if (src_pulse) tgl_q <= ~tgl_q;
    end

    lft_sync #(.WIDTH(1), .STAGES(STAGES)) u_sync (
        .clk(dst_clk), .rst(dst_rst), .d(tgl_q), .q(tgl_s)
    );

    always_ff @(posedge dst_clk) begin
        if (dst_rst) tgl_d <= 1'b0;
        else         tgl_d <= tgl_s;
    end

    assign dst_pulse = tgl_s ^ tgl_d;
endmodule

// File: rtl/lft_slow_core.sv
module lft_slow_core #(
    parameter int CNT_W  = 28,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_p,
    input  logic             stop_p,
    input  logic             reload_upd_p,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             enable_lvl,
    input  logic             halt_en_lvl,
    input  logic             dbg_halt,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] shadow,
    output logic             run,
    output logic             active,
    output logic             load_ev,
    output logic             expire_ev
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [2:0] lvl_s;

    lft_sync #(.WIDTH(3), .STAGES(STAGES)) u_lvl (
        .clk(clk), .rst(rst),
        .d({dbg_halt, halt_en_lvl, enable_lvl}),
        .q(lvl_s)
    );

    assign active    = run & lvl_s[0] & ~(lvl_s[1] & lvl_s[2]);
    assign load_ev   = start_p;
    assign expire_ev = active & ~start_p & ~stop_p & (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            shadow <= '0;
            run    <= 1'b0;
        end else begin
            if (reload_upd_p) shadow <= reload_val;
            // a start always follows the most recent stop on the bus side
            if (start_p) begin
                cnt    <= reload_val;
                shadow <= reload_val;
                run    <= 1'b1;
            end else if (stop_p) begin
                run <= 1'b0;
            end else if (active) begin
                if (cnt == '0) cnt <= shadow;
                else           cnt <= cnt - ONE;
            end
        end
    end
endmodule

// File: rtl/lft_bus_regs.sv
module lft_bus_regs
    import lft_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              load_ack,
    input  logic              expire_in,
    input  logic              tick_in,
    input  logic [CNT_W-1:0]  cnt_slow,
    input  logic              run_sync,
    output lft_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  reload_q,
    output logic              start_rise,
    output logic              start_fall,
    output logic              reload_wr,
    output logic              pend,
    output logic              expired,
    output logic              irq
);
    lft_addr_e        a;
    lft_ctrl_t        wctrl;
    lft_status_t      stat;
    logic [CNT_W-1:0] cnt_mirror;
    logic             unused_wbits;

    assign a            = lft_addr_e'(addr);
    assign wctrl        = lft_ctrl_t'(wdata[CTRL_W-1:0]);
    assign unused_wbits = ^wdata[DATA_W-1:CNT_W];

    assign start_rise = wr && (a == ADR_CTRL) &&  wctrl.start && !ctrl.start;
    assign start_fall = wr && (a == ADR_CTRL) && !wctrl.start &&  ctrl.start;
    assign reload_wr  = wr && (a == ADR_RELOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= '0;
            reload_q   <= '0;
            pend       <= 1'b0;
            expired    <= 1'b0;
            cnt_mirror <= '0;
            irq        <= 1'b0;
        end else begin
            if (wr && a == ADR_CTRL)   ctrl     <= wctrl;
            if (reload_wr)             reload_q <= wdata[CNT_W-1:0];
            if (start_rise)                   pend <= 1'b1;
            else if (start_fall || load_ack)  pend <= 1'b0;
            if (tick_in) cnt_mirror <= cnt_slow;
            if (expire_in)
                expired <= 1'b1;
            else if (wr && a == ADR_STATUS && wdata[0] && !ctrl.start)
                expired <= 1'b0;
            irq <= expired & ctrl.irq_en;
        end
    end

    assign stat.expired  = expired;
    assign stat.counting = run_sync & ctrl.start & ~pend;

    always_comb begin
        unique case (a)
            ADR_RELOAD: rdata = lft_zext(DATA_W'(reload_q), CNT_W);
            ADR_CTRL:   rdata = DATA_W'(ctrl);
            ADR_COUNT:  rdata = pend ? '0 : lft_zext(DATA_W'(cnt_mirror), CNT_W);
            default:    rdata = DATA_W'(stat);
        endcase
    end
endmodule

// File: rtl/lft_tick_timer.sv
module lft_tick_timer
    import lft_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int STAGES = SYNC_DEF
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              slow_clk,
    input  logic              slow_rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dbg_halt,
    output logic              irq_out
);
    localparam int N_XING = 3;

    lft_ctrl_t        ctrl;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] shadow;
    logic             start_rise, start_fall, reload_wr;
    logic             pend, expired;
    logic             start_p, stop_p, reload_upd_p;
    logic             run, active, load_ev, expire_ev;
    logic             run_b, load_b, expire_b, tick_b;
    logic [N_XING-1:0] b2s_src, b2s_dst, s2b_src, s2b_dst;

    assign b2s_src = {reload_wr, start_fall, start_rise};
    assign {reload_upd_p, stop_p, start_p} = b2s_dst;
    assign s2b_src = {1'b1, expire_ev, load_ev};
    assign {tick_b, expire_b, load_b} = s2b_dst;

    for (genvar i = 0; i < N_XING; i++) begin : g_xing
        lft_pulse_xing #(.STAGES(STAGES)) u_b2s (
            .src_clk(bus_clk), .src_rst(bus_rst), .src_pulse(b2s_src[i]),
            .dst_clk(slow_clk), .dst_rst(slow_rst), .dst_pulse(b2s_dst[i])
        );
        lft_pulse_xing #(.STAGES(STAGES)) u_s2b (
            .src_clk(slow_clk), .src_rst(slow_rst), .src_pulse(s2b_src[i]),
            .dst_clk(bus_clk), .dst_rst(bus_rst), .dst_pulse(s2b_dst[i])
        );
    end

    lft_sync #(.WIDTH(1), .STAGES(STAGES)) u_run_sync (
        .clk(bus_clk), .rst(bus_rst), .d(run), .q(run_b)
    );

    lft_bus_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(bus_clk), .rst(bus_rst), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .load_ack(load_b), .expire_in(expire_b), .tick_in(tick_b),
        .cnt_slow(cnt), .run_sync(run_b),
        .ctrl(ctrl), .reload_q(reload_q),
        .start_rise(start_rise), .start_fall(start_fall), .reload_wr(reload_wr),
        .pend(pend), .expired(expired), .irq(irq_out)
    );

    lft_slow_core #(.CNT_W(CNT_W), .STAGES(STAGES)) u_core (
        .clk(slow_clk), .rst(slow_rst),
        .start_p(start_p), .stop_p(stop_p), .reload_upd_p(reload_upd_p),
        .reload_val(reload_q), .enable_lvl(ctrl.enable),
        .halt_en_lvl(ctrl.halt_en), .dbg_halt(dbg_halt),
        .cnt(cnt), .shadow(shadow), .run(run), .active(active),
        .load_ev(load_ev), .expire_ev(expire_ev)
    );
endmodule

// File: rtl/lft_tick_timer_chk.sv
module lft_tick_timer_chk
    import lft_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input logic              bus_clk,
    input logic              bus_rst,
    input logic              slow_clk,
    input logic              slow_rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_out,
    input logic              pend,
    input logic              expired,
    input logic              start_q,
    input logic              irq_en,
    input logic              start_p,
    input logic              stop_p,
    input logic              active,
    input logic              run,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  shadow,
    input logic [CNT_W-1:0]  reload_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    a_r1_step: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (run && active && !start_p && !stop_p && cnt != '0) |=> (cnt == $past(cnt) - ONE));

    a_r4_reload: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (run && active && !start_p && !stop_p && cnt == '0) |=> (cnt == $past(shadow)));

    a_r9_hold: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (run && !active && !start_p && !stop_p) |=> $stable(cnt));

    a_r3_load: assert property (@(posedge slow_clk) disable iff (slow_rst)
        start_p |=> (run && cnt == $past(reload_q)));

    a_r5_pend_zero: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (pend && reg_addr == ADR_COUNT) |-> (reg_rdata == '0));

    a_r2_top_zero: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (reg_addr == ADR_COUNT) |-> (reg_rdata[DATA_W-1:CNT_W] == '0));

    a_r7_sticky: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (expired && start_q) |=> expired);

    a_r8_irq_gate: assert property (@(posedge bus_clk) disable iff (bus_rst)
        !irq_en |=> !irq_out);
endmodule

bind lft_tick_timer lft_tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .slow_clk(slow_clk), .slow_rst(slow_rst),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq_out(irq_out),
    .pend(pend), .expired(expired), .start_q(ctrl.start), .irq_en(ctrl.irq_en),
    .start_p(start_p), .stop_p(stop_p), .active(active), .run(run),
    .cnt(cnt), .shadow(shadow), .reload_q(reload_q)
);

// File: tb/lft_tick_timer_tb_top.sv
module lft_tick_timer_tb_top;
    localparam int CLK_PERIOD  = 10;
    localparam int SLOW_PERIOD = 80;
    localparam int NV = 6;
    localparam int unsigned TB_PL[NV] = '{100, 5, 5, 0, 3, 20};
    localparam int unsigned TB_WT[NV] = '{7, 6, 13, 3, 2, 20};

    logic        bus_clk = 1'b0, slow_clk = 1'b0;
    logic        bus_rst = 1'b1, slow_rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dbg_halt = 1'b0;
    logic        irq_out;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2)  bus_clk  = ~bus_clk;
    always #(SLOW_PERIOD/2) slow_clk = ~slow_clk;

    lft_tick_timer dut_i (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .slow_clk(slow_clk), .slow_rst(slow_rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dbg_halt(dbg_halt), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input logic [31:0] act,
                             input logic [31:0] lo, input logic [31:0] hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge bus_clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic slow_cycles(input int n);
        repeat (n) @(posedge slow_clk);
    endtask

    task automatic sync_slow;
        @(posedge slow_clk);
        #(SLOW_PERIOD/2 - 3);
    endtask

    task automatic wait_counting;
        logic [31:0] s;
        for (int i = 0; i < 100; i++) begin
            rd(2'd3, s);
            if (s[1]) break;
        end
    endtask

    task automatic start_timer(input logic [31:0] p, input logic [31:0] c);
        wr(2'd1, 32'h0);
        slow_cycles(4);
        wr(2'd0, p);
        wr(2'd1, c);
        wait_counting;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run;
    end

    initial begin
        logic [31:0] v, c0, c1, e;
        slow_cycles(4);
        #(SLOW_PERIOD/4);
        bus_rst = 1'b0; slow_rst = 1'b0;

        // R11 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R11 reset read", v, 32'h0);
        end
        check("R11 irq low", {31'b0, irq_out}, 32'h0);

        // R2 width of reload value
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v);
        check("R2 reload upper bits", v, 32'h0FFF_FFFF);

        // R3 count is read-only
        wr(2'd2, 32'h1234);
        rd(2'd2, v);
        check("R3 count write ignored", v, 32'h0);

        // R5 synchronization window
        wr(2'd0, 32'd100);
        wr(2'd1, 32'h9);
        rd(2'd2, v);
        check("R5 count zero while pending", v, 32'h0);
        rd(2'd1, v);
        check("R5 start reads set", v, 32'h9);
        rd(2'd3, v);
        check("R6 counting low while pending", {31'b0, v[1]}, 32'h0);

        // R3 / R6 load after crossing
        slow_cycles(6);
        rd(2'd3, v);
        check("R6 counting set after load", {31'b0, v[1]}, 32'h1);
        rd(2'd2, v);
        check_rng("R3 loaded from reload", v, 32'd90, 32'd100);

        // R1 / R4 vector table
        for (int k = 0; k < NV; k++) begin
            start_timer(TB_PL[k], 32'h9);
            sync_slow;
            rd(2'd2, c0);
            slow_cycles(TB_WT[k]);
            #(SLOW_PERIOD/2 - 3);
            rd(2'd2, c1);
            e = (c0 + TB_PL[k] + 1 - (TB_WT[k] % (TB_PL[k] + 1))) % (TB_PL[k] + 1);
            check($sformatf("R1 R4 vector %0d", k), c1, e);
        end

        // R7 / R8 sticky status and interrupt gate
        rd(2'd3, v);
        check("R7 expiry sets status", {31'b0, v[0]}, 32'h1);
        wr(2'd3, 32'h1);
        rd(2'd3, v);
        check("R7 clear ignored while started", {31'b0, v[0]}, 32'h1);
        check("R8 irq low without enable", {31'b0, irq_out}, 32'h0);
        wr(2'd1, 32'h0);
        rd(2'd3, v);
        check("R6 counting clear after stop", {31'b0, v[1]}, 32'h0);
        slow_cycles(5);
        wr(2'd1, 32'h2);
        @(negedge bus_clk);
        check("R8 irq high with enable", {31'b0, irq_out}, 32'h1);
        wr(2'd3, 32'h1);
        rd(2'd3, v);
        check("R7 clear when stopped", {31'b0, v[0]}, 32'h0);
        @(negedge bus_clk);
        check("R8 irq follows clear", {31'b0, irq_out}, 32'h0);

        // R4 reload-value change while running
        start_timer(32'd50, 32'h9);
        wr(2'd0, 32'd10);
        sync_slow;
        rd(2'd2, v);
        check_rng("R4 running count unchanged", v, 32'd30, 32'd50);
        slow_cycles(60);
        sync_slow;
        rd(2'd2, v);
        check_rng("R4 new period after reload", v, 32'd0, 32'd10);

        // R9 enable clear holds count
        start_timer(32'd1000, 32'h8);
        sync_slow;
        rd(2'd2, c0);
        slow_cycles(10);
        #(SLOW_PERIOD/2 - 3);
        rd(2'd2, c1);
        check("R9 hold when disabled", c1, c0);

        // R10 debug halt
        @(posedge slow_clk);
        #(SLOW_PERIOD/4);
        dbg_halt = 1'b1;
        start_timer(32'd1000, 32'hD);
        slow_cycles(4);
        sync_slow;
        rd(2'd2, c0);
        slow_cycles(10);
        #(SLOW_PERIOD/2 - 3);
        rd(2'd2, c1);
        check("R10 frozen by debug halt", c1, c0);
        wr(2'd1, 32'h9);
        slow_cycles(4);
        sync_slow;
        rd(2'd2, c0);
        slow_cycles(10);
        #(SLOW_PERIOD/2 - 3);
        rd(2'd2, c1);
        check("R10 halt ignored without mode", c1, c0 - 32'd10);

        finish_run;
    end
endmodule